// File: doc/BRIEF.md
# SDRAM Auto-Precharge Interrupt Scheduler

This block sits on the controller side of a multi-bank SDRAM. It turns a simple request stream into column commands that carry auto precharge, with a fixed burst of four beats. A request is a bank, a column and a read/write flag. Each accepted request reaches the command outputs a fixed three cycles later. That delay gives the block time to raise the data mask ahead of a write that would otherwise meet read data still coming back on the bus.

A command to a different bank may cut short a burst that is still running. When this happens, the interrupted write's recovery time starts from the interrupting command. An interrupted read begins precharging at once. Any remaining beats of the old burst are dropped from the data-enable outputs.

One timer per bank tracks the bank through four phases: burst, write-back, precharge and idle. A request to a bank that is not idle, or that still has a command in flight, is held off with a low ready. It waits until the bank can be opened again.

Top module: `sdap_sched`

## Requirements
- R1: After reset the command output is NOP (code 2'b00), DQM, write-enable and read-valid are low, every bank reports idle and a request is ready.
- R2: A request accepted at the clock edge ending cycle t shows on the command outputs in cycle t+3, with its bank and column. The code is 2'b01 for a read and 2'b10 for a write. Every other cycle shows NOP.
- R3: A write command shown in cycle C raises the write-data enable in cycles C to C+3. A later command shown in cycle C' removes the beats at C' and after, so the last counted beat is C'-1.
- R4: A read command shown in cycle C raises read-valid in cycles C+CAS_LAT to C+CAS_LAT+3. A later read shown in C' removes old beats from C'+CAS_LAT on. A later write shown in C' removes old beats from C' on.
- R5: DQM is high for exactly one cycle, C'-2, when a write shown in C' lands on a read beat that was due in cycle C'. Otherwise DQM stays low, including when a read follows a write.
- R6: For a write shown in cycle C, its bank leaves idle in cycle C. Write-back starts at W = min(C', C+4), where C' is the next command to another bank. The bank is idle again from W+T_WR+T_RP.
- R7: For a read shown in cycle C, its bank leaves idle in cycle C. Precharge starts at P = min(C', C+4). The bank is idle again from P+T_RP.
- R8: Ready is low for a bank that is not idle or that has an accepted command not yet shown. A held request is accepted in the first cycle its bank reports idle, and it is not dropped.
- R9: A request to an idle bank with nothing in flight is ready, even while another bank's burst is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request will be accepted at this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | $clog2(NUM_BANKS) | Target bank |
| req_col | input | COL_W | Start column |
| cmd_o | output | 2 | Command code: 00 NOP, 01 read with auto precharge, 10 write with auto precharge |
| cmd_bank_o | output | $clog2(NUM_BANKS) | Bank of the shown command |
| cmd_col_o | output | COL_W | Column of the shown command |
| dqm_o | output | 1 | Data mask |
| wdata_en_o | output | 1 | Write data beat to drive this cycle |
| rdata_vld_o | output | 1 | Read data beat arrives this cycle |
| bank_idle_o | output | NUM_BANKS | Per-bank idle flag |

## Verification
The bench builds the block with four banks, a 6-bit column, CAS latency 3, T_WR 2 and T_RP 3. It sweeps every ordered pair of distinct banks, all four read/write combinations and request gaps of 1 to 8 cycles. With these values a gap of 3 to 6 makes each of the four read beats in turn the one that collides with a following write. Shorter gaps cut bursts before data returns, and longer gaps let the first burst finish without interruption. Same-bank requests held through the full write-back and precharge window check the stall path against arithmetic idle times.

// File: rtl/sdap_pkg.sv
package sdap_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_RD  = 2'b01,
    CMD_WR  = 2'b10
  } cmd_e;

  typedef enum logic [1:0] {
    BK_IDLE,
    BK_BURST,
    BK_WRBACK,
    BK_PRECH
  } bank_st_e;

  localparam int BURST_LEN = 4;
  // cycles from request acceptance to the command being shown
  localparam int ISSUE_LAT = 3;
endpackage

// File: rtl/sdap_issue_pipe.sv
module sdap_issue_pipe #(
  parameter int BANK_W = 2,
  parameter int COL_W  = 10,
  parameter int DEPTH  = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          in_vld,
  input  logic                          in_wr,
  input  logic [BANK_W-1:0]             in_bank,
  input  logic [COL_W-1:0]              in_col,
  output logic [DEPTH-1:0]              tap_vld,
  output logic [DEPTH-1:0][BANK_W-1:0]  tap_bank,
  output logic                          out_wr,
  output logic [COL_W-1:0]              out_col
);
  logic [DEPTH-1:0]             wr_q;
  logic [DEPTH-1:0][COL_W-1:0]  col_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tap_vld  <= '0;
      tap_bank <= '0;
      wr_q     <= '0;
      col_q    <= '0;
    end else begin
      tap_vld[0]  <= in_vld;
      tap_bank[0] <= in_bank;
      wr_q[0]     <= in_wr;
      col_q[0]    <= in_col;
    end
  end

  generate
    for (genvar s = 1; s < DEPTH; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) begin
          tap_vld[s]  <= 1'b0;
          tap_bank[s] <= '0;
          wr_q[s]     <= 1'b0;
          col_q[s]    <= '0;
        end else begin
          tap_vld[s]  <= tap_vld[s-1];
          tap_bank[s] <= tap_bank[s-1];
          wr_q[s]     <= wr_q[s-1];
          col_q[s]    <= col_q[s-1];
        end
      end
    end
  endgenerate

  assign out_wr  = wr_q[DEPTH-1];
  assign out_col = col_q[DEPTH-1];
endmodule

// File: rtl/sdap_bank.sv
module sdap_bank #(
  parameter int T_WR = 2,
  parameter int T_RP = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic issue,
  input  logic issue_wr,
  input  logic other_issue,
  output logic idle_o
);
  import sdap_pkg::*;

  localparam int MAX_A = (T_WR > BURST_LEN) ? T_WR : BURST_LEN;
  localparam int MAX_C = (T_RP > MAX_A) ? T_RP : MAX_A;
  localparam int CNT_W = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] C_BL = CNT_W'(BURST_LEN);
  localparam logic [CNT_W-1:0] C_WR = CNT_W'(T_WR);
  localparam logic [CNT_W-1:0] C_RP = CNT_W'(T_RP);
  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);

  bank_st_e         st;
  logic [CNT_W-1:0] cnt;
  logic             wr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= BK_IDLE;
      cnt  <= '0;
      wr_q <= 1'b0;
    end else if (issue) begin
      st   <= BK_BURST;
      cnt  <= C_BL;
      wr_q <= issue_wr;
    end else begin
      case (st)
        BK_BURST: begin
          // the next shown command to another bank ends the burst early
          if (other_issue || cnt == C_ONE) begin
            if (wr_q) begin
              st  <= BK_WRBACK;
              cnt <= C_WR;
            end else begin
              st  <= BK_PRECH;
              cnt <= C_RP;
            end
          end else begin
            cnt <= cnt - C_ONE;
          end
        end
        BK_WRBACK: begin
          if (cnt == C_ONE) begin
            st  <= BK_PRECH;
            cnt <= C_RP;
          end else begin
            cnt <= cnt - C_ONE;
          end
        end
        BK_PRECH: begin
          if (cnt == C_ONE) st <= BK_IDLE;
          else              cnt <= cnt - C_ONE;
        end
        default: ;
      endcase
    end
  end

  assign idle_o = (st == BK_IDLE);
endmodule

// File: rtl/sdap_beats.sv
module sdap_beats #(
  parameter int CAS_LAT = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic accept,
  input  logic acc_wr,
  output logic wdata_en,
  output logic rdata_vld,
  output logic dqm
);
  import sdap_pkg::*;

  // index k of each vector = beat due k cycles after the current one
  localparam int NEAR  = ISSUE_LAT - 1;
  localparam int RV_N  = NEAR + CAS_LAT + BURST_LEN;
  localparam int WV_N  = NEAR + BURST_LEN;
  localparam int RD_AT = NEAR + CAS_LAT;

  logic [RV_N-1:0] rvec, rv_n;
  logic [WV_N-1:0] wvec, wv_n;
  logic            dqm_q, dqm_n;

  always_comb begin
    rv_n  = {1'b0, rvec[RV_N-1:1]};
    wv_n  = {1'b0, wvec[WV_N-1:1]};
    dqm_n = 1'b0;
    if (accept) begin
      for (int k = NEAR; k < WV_N; k++) wv_n[k] = 1'b0;
      if (acc_wr) begin
        dqm_n = rvec[ISSUE_LAT];
        for (int k = NEAR; k < RV_N; k++) rv_n[k] = 1'b0;
        for (int k = NEAR; k < WV_N; k++) wv_n[k] = 1'b1;
      end else begin
        for (int k = RD_AT; k < RV_N; k++) rv_n[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rvec  <= '0;
      wvec  <= '0;
      dqm_q <= 1'b0;
    end else begin
      rvec  <= rv_n;
      wvec  <= wv_n;
      dqm_q <= dqm_n;
    end
  end

  assign rdata_vld = rvec[0];
  assign wdata_en  = wvec[0];
  assign dqm       = dqm_q;
endmodule

// File: rtl/sdap_sched.sv
module sdap_sched #(
  parameter int NUM_BANKS = 4,
  parameter int COL_W     = 10,
  parameter int T_WR      = 2,
  parameter int T_RP      = 3,
  parameter int CAS_LAT   = 3,
  localparam int BANK_W   = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic                 req_write,
  input  logic [BANK_W-1:0]    req_bank,
  input  logic [COL_W-1:0]     req_col,
  output logic [1:0]           cmd_o,
  output logic [BANK_W-1:0]    cmd_bank_o,
  output logic [COL_W-1:0]     cmd_col_o,
  output logic                 dqm_o,
  output logic                 wdata_en_o,
  output logic                 rdata_vld_o,
  output logic [NUM_BANKS-1:0] bank_idle_o
);
  import sdap_pkg::*;

  localparam int DEPTH = ISSUE_LAT - 1;

  logic                         accept;
  logic [DEPTH-1:0]             tap_vld;
  logic [DEPTH-1:0][BANK_W-1:0] tap_bank;
  logic                         last_wr;
  logic [COL_W-1:0]             last_col;
  logic                         last_vld;
  logic [BANK_W-1:0]            last_bank;
  logic                         pend_same;

  assign accept = req_valid && req_ready;

  sdap_issue_pipe #(.BANK_W(BANK_W), .COL_W(COL_W), .DEPTH(DEPTH)) u_pipe (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (accept),
    .in_wr    (req_write),
    .in_bank  (req_bank),
    .in_col   (req_col),
    .tap_vld  (tap_vld),
    .tap_bank (tap_bank),
    .out_wr   (last_wr),
    .out_col  (last_col)
  );

  assign last_vld  = tap_vld[DEPTH-1];
  assign last_bank = tap_bank[DEPTH-1];

  always_comb begin
    pend_same = 1'b0;
    for (int s = 0; s < DEPTH; s++)
      if (tap_vld[s] && tap_bank[s] == req_bank) pend_same = 1'b1;
  end

  assign req_ready = bank_idle_o[req_bank] && !pend_same;

  generate
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      logic hit;
      assign hit = (last_bank == BANK_W'(b));
      sdap_bank #(.T_WR(T_WR), .T_RP(T_RP)) u_bank (
        .clk         (clk),
        .rst         (rst),
        .issue       (last_vld && hit),
        .issue_wr    (last_wr),
        .other_issue (last_vld && !hit),
        .idle_o      (bank_idle_o[b])
      );
    end
  endgenerate

  sdap_beats #(.CAS_LAT(CAS_LAT)) u_beats (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .acc_wr    (req_write),
    .wdata_en  (wdata_en_o),
    .rdata_vld (rdata_vld_o),
    .dqm       (dqm_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_o      <= CMD_NOP;
      cmd_bank_o <= '0;
      cmd_col_o  <= '0;
    end else begin
      cmd_o      <= !last_vld ? CMD_NOP : (last_wr ? CMD_WR : CMD_RD);
      cmd_bank_o <= last_bank;
      cmd_col_o  <= last_col;
    end
  end
endmodule

// File: rtl/sdap_sched_chk.sv
module sdap_sched_chk #(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_ready,
  input logic [BANK_W-1:0]    req_bank,
  input logic [1:0]           cmd_o,
  input logic [BANK_W-1:0]    cmd_bank_o,
  input logic                 dqm_o,
  input logic                 wdata_en_o,
  input logic                 rdata_vld_o,
  input logic [NUM_BANKS-1:0] bank_idle_o
);
  logic [NUM_BANKS-1:0] idle_prev;

  always_ff @(posedge clk) begin
    if (rst) idle_prev <= '1;
    else     idle_prev <= bank_idle_o;
  end

  // R5: a mask pulse is followed two cycles later by a write command
  assert_dqm_leads_write_R5: assert property (@(posedge clk) disable iff (rst)
    dqm_o |-> ##2 (cmd_o == 2'b10));

  // R3/R4: the data bus never carries write and read beats together
  assert_no_bus_clash_R3: assert property (@(posedge clk) disable iff (rst)
    !(wdata_en_o && rdata_vld_o));

  // R3: a fresh write burst starts only with a write command
  assert_wburst_start_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(wdata_en_o) |-> (cmd_o == 2'b10));

  // R8: a command only opens a bank that was idle the cycle before
  assert_cmd_on_idle_R8: assert property (@(posedge clk) disable iff (rst)
    (cmd_o != 2'b00) |-> idle_prev[cmd_bank_o]);

  // R6/R7: the addressed bank leaves idle while its command is shown
  assert_bank_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (cmd_o != 2'b00) |-> !bank_idle_o[cmd_bank_o]);

  // R8: ready is never offered to a busy bank
  assert_ready_idle_R8: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> bank_idle_o[req_bank]);
endmodule

bind sdap_sched sdap_sched_chk #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_ready   (req_ready),
  .req_bank    (req_bank),
  .cmd_o       (cmd_o),
  .cmd_bank_o  (cmd_bank_o),
  .dqm_o       (dqm_o),
  .wdata_en_o  (wdata_en_o),
  .rdata_vld_o (rdata_vld_o),
  .bank_idle_o (bank_idle_o)
);

// File: tb/sdap_sched_bench.sv
module sdap_sched_bench;
  localparam int NB  = 4;
  localparam int CW  = 6;
  localparam int TWR = 2;
  localparam int TRP = 3;
  localparam int CL  = 3;
  localparam int WIN = 24;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid, req_ready, req_write;
  logic [1:0]    req_bank;
  logic [CW-1:0] req_col;
  logic [1:0]    cmd_o, cmd_bank_o;
  logic [CW-1:0] cmd_col_o;
  logic          dqm_o, wdata_en_o, rdata_vld_o;
  logic [NB-1:0] bank_idle_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sdap_sched #(.NUM_BANKS(NB), .COL_W(CW), .T_WR(TWR), .T_RP(TRP), .CAS_LAT(CL)) u_sdap_sched (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_bank(req_bank), .req_col(req_col),
    .cmd_o(cmd_o), .cmd_bank_o(cmd_bank_o), .cmd_col_o(cmd_col_o),
    .dqm_o(dqm_o), .wdata_en_o(wdata_en_o), .rdata_vld_o(rdata_vld_o),
    .bank_idle_o(bank_idle_o)
  );

  logic [1:0]    r_cmd [64];
  logic [1:0]    r_bnk [64];
  logic [CW-1:0] r_col [64];
  logic          r_wen [64];
  logic          r_rvl [64];
  logic          r_dqm [64];
  logic [NB-1:0] r_idl [64];

  always @(negedge clk) begin
    r_cmd[cyc % 64] = cmd_o;
    r_bnk[cyc % 64] = cmd_bank_o;
    r_col[cyc % 64] = cmd_col_o;
    r_wen[cyc % 64] = wdata_en_o;
    r_rvl[cyc % 64] = rdata_vld_o;
    r_dqm[cyc % 64] = dqm_o;
    r_idl[cyc % 64] = bank_idle_o;
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  function automatic int mn(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic drive(input int b, input bit wr, input int col);
    req_valid = 1'b1;
    req_bank  = 2'(b);
    req_write = wr;
    req_col   = CW'(col);
  endtask

  task automatic run_pair(input int a, input int b, input bit w1, input bit w2, input int g);
    int t1, c1, c2, wa, ia, ib, col1, col2;
    col1 = (a * 11 + g) % 64;
    col2 = (b * 5 + g * 3 + 1) % 64;
    @(negedge clk);
    t1 = cyc;
    drive(a, w1, col1);
    for (int k = 1; k <= g; k++) begin
      @(negedge clk);
      if (k == g) begin
        drive(b, w2, col2);
        #1;
        chk("R9", "ready other bank", int'(req_ready), 1);
      end else begin
        req_valid = 1'b0;
      end
    end
    @(negedge clk);
    req_valid = 1'b0;
    repeat (26) @(negedge clk);
    c1 = t1 + 3;
    c2 = t1 + g + 3;
    wa = mn(c2, c1 + 4);
    ia = w1 ? wa + TWR + TRP : wa + TRP;
    ib = c2 + 4 + (w2 ? TWR : 0) + TRP;
    for (int k = 0; k < WIN; k++) begin
      int c, ix, e_cmd, e_wen, e_rvl, e_dqm;
      c  = t1 + k;
      ix = c % 64;
      e_cmd = (c == c1) ? (w1 ? 2 : 1) : (c == c2) ? (w2 ? 2 : 1) : 0;
      chk("R2", "command code", int'(r_cmd[ix]), e_cmd);
      if (c == c1) begin
        chk("R2", "bank first", int'(r_bnk[ix]), a);
        chk("R2", "column first", int'(r_col[ix]), col1);
      end
      if (c == c2) begin
        chk("R2", "bank second", int'(r_bnk[ix]), b);
        chk("R2", "column second", int'(r_col[ix]), col2);
      end
      e_wen = ((w1 && c >= c1 && c < c1 + 4 && c < c2) ||
               (w2 && c >= c2 && c < c2 + 4)) ? 1 : 0;
      chk("R3", "write enable", int'(r_wen[ix]), e_wen);
      e_rvl = ((!w1 && c >= c1 + CL && c < c1 + CL + 4 && (w2 ? c < c2 : c < c2 + CL)) ||
               (!w2 && c >= c2 + CL && c < c2 + CL + 4)) ? 1 : 0;
      chk("R4", "read valid", int'(r_rvl[ix]), e_rvl);
      e_dqm = (!w1 && w2 && c == c2 - 2 && c2 >= c1 + CL && c2 < c1 + CL + 4) ? 1 : 0;
      chk("R5", "dqm", int'(r_dqm[ix]), e_dqm);
      chk(w1 ? "R6" : "R7", "idle first bank", int'(r_idl[ix][a]), (c < c1 || c >= ia) ? 1 : 0);
      chk(w2 ? "R6" : "R7", "idle second bank", int'(r_idl[ix][b]), (c < c2 || c >= ib) ? 1 : 0);
    end
  endtask

  task automatic run_stall(input int a, input bit w1, input bit w2);
    int t1, ta, exp_ta, ix;
    @(negedge clk);
    t1 = cyc;
    drive(a, w1, 7);
    @(negedge clk);
    drive(a, w2, 9);
    #1;
    chk("R8", "ready while pending", int'(req_ready), 0);
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    ta = cyc;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (20) @(negedge clk);
    exp_ta = t1 + 3 + 4 + (w1 ? TWR : 0) + TRP;
    chk("R8", "accept cycle after stall", ta - t1, exp_ta - t1);
    ix = (ta + 3) % 64;
    chk("R8", "held command shown", int'(r_cmd[ix]), w2 ? 2 : 1);
    chk("R8", "held command bank", int'(r_bnk[ix]), a);
    chk("R8", "held command column", int'(r_col[ix]), 9);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst       = 1'b1;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_bank  = '0;
    req_col   = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    chk("R1", "cmd after reset", int'(cmd_o), 0);
    chk("R1", "dqm after reset", int'(dqm_o), 0);
    chk("R1", "wen after reset", int'(wdata_en_o), 0);
    chk("R1", "rvl after reset", int'(rdata_vld_o), 0);
    chk("R1", "idle after reset", int'(bank_idle_o), (1 << NB) - 1);
    chk("R1", "ready after reset", int'(req_ready), 1);

    for (int a = 0; a < NB; a++)
      for (int b = 0; b < NB; b++)
        if (a != b)
          for (int ops = 0; ops < 4; ops++)
            for (int g = 1; g <= 8; g++)
              run_pair(a, b, ops[1], ops[0], g);

    for (int a = 0; a < NB; a++)
      for (int ops = 0; ops < 4; ops++)
        run_stall(a, ops[1], ops[0]);

    finish_run();
  end
endmodule